// File: doc/BRIEF.md
# Sv32 Two-Level Address Translator

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level Sv32 page table held in memory. The requester hands over one request at a time: a virtual address, an access kind (instruction fetch, data load or data store) and the current translation control word. The translator then reads the level-1 entry and, if that entry points onward, the level-0 entry. It checks the leaf against the access kind and sets the accessed and dirty flags in memory when they are not already set. It answers with either a physical address or a page-fault cause together with the offending virtual address.

The same sequencer serves fetch and data traffic. The access kind alone decides which permission bit is required, which fault cause is reported and whether the dirty flag is written. Memory is reached through a single request/acknowledge port with at most one access outstanding. When translation is disabled, the virtual address passes through unchanged and no memory access is made. Caching of translations and trap handling belong to the surrounding core.

Top module: `sv32_walker`

## Requirements
- R1: When `satp[31]` is 0, a request completes without any memory access, with `fault`=0 and `pa` equal to the virtual address zero-extended to 34 bits.
- R2: With `satp[31]`=1, the first read goes to `satp[21:0]`×4096 + VA[31:22]×4. A pointer entry (V=1, R=W=X=0) leads to a second read at PTE[31:10]×4096 + VA[21:12]×4.
- R3: PTE bits are V=0, R=1, W=2, X=3, A=6, D=7. A leaf must have X=1 for a fetch, R=1 for a load and W=1 for a store; otherwise the request faults.
- R4: The fault cause is 12 for a fetch, 13 for a load and 15 for a store.
- R5: A leaf found at level 1 maps a 4 MiB page with `pa` = {PTE[31:20], VA[21:0]}. If PTE[19:10] is non-zero, the request faults.
- R6: A leaf found at level 0 gives `pa` = {PTE[31:10], VA[11:0]}.
- R7: An entry with V=0, an entry with R=0 and W=1, and a pointer found at level 0 each end the walk with a fault within a bounded number of cycles. No further read is made after such an entry.
- R8: For a permitted leaf, fetch and load set only A, and store sets A and D. The updated entry is written back to the address it was read from before `done`.
- R9: When the flags a request needs are already set, no write is issued.
- R10: On a fault, `fault_va` equals the virtual address of the request.
- R11: `mem_req`, `mem_we` and `mem_addr` hold steady from the cycle a request is raised until the cycle `mem_ack` is seen.
- R12: `done` is a one-cycle pulse. `req_ready` is high only while idle, during which no memory request is made. Reset returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| satp | input | 32 | Bit 31 enables translation; bits 21:0 give the root page number |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write of `mem_wdata` |
| mem_addr | output | 34 | Byte address of the page-table entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| done | output | 1 | Result valid for one cycle |
| fault | output | 1 | Translation failed |
| cause | output | 4 | Page-fault cause code |
| pa | output | 34 | Translated physical address |
| fault_va | output | 32 | Virtual address that failed |

## Verification
The assertions take for granted that `req_kind` never carries the unused code 3, and that memory answers each request with exactly one `mem_ack` while the request is held, never acknowledging when nothing is asked. The bench memory model raises a single acknowledge after a latency that rotates through zero to two extra cycles. It never acknowledges an idle port, and every request the bench issues uses one of the three legal kind codes. The page-table image is reloaded before each case, so write-backs from one case never change the flags seen by the next.

// File: rtl/sv32w_pkg.sv
package sv32w_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned PTE_W  = 32;
  localparam int unsigned OFS_W  = 12;
  localparam int unsigned VPN_W  = 10;
  localparam int unsigned PPN_W  = 22;
  localparam int unsigned PA_W   = PPN_W + OFS_W;
  localparam int unsigned CAUSE_W = 4;

  // flag positions inside a table entry
  localparam int unsigned B_V = 0;
  localparam int unsigned B_R = 1;
  localparam int unsigned B_W = 2;
  localparam int unsigned B_X = 3;
  localparam int unsigned B_A = 6;
  localparam int unsigned B_D = 7;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  localparam logic [CAUSE_W-1:0] CAUSE_FETCH_PF = 4'd12;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD_PF  = 4'd13;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE_PF = 4'd15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_RD,
    ST_L1_WB,
    ST_L0_RD,
    ST_L0_WB,
    ST_RESP
  } wstate_e;
endpackage

// File: rtl/sv32w_pte_addr.sv
module sv32w_pte_addr
  import sv32w_pkg::*;
(
  input  logic             lvl1,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic [PPN_W-1:0] next_ppn,
  input  logic [VA_W-1:0]  va,
  output logic [PA_W-1:0]  addr
);
  localparam int unsigned VPN1_LO = OFS_W + VPN_W;

  logic [PPN_W-1:0] base;
  logic [VPN_W-1:0] idx;

  always_comb begin
    base = lvl1 ? root_ppn : next_ppn;
    idx  = lvl1 ? va[VA_W-1:VPN1_LO] : va[VPN1_LO-1:OFS_W];
    addr = {base, idx, 2'b00};
  end
endmodule

// File: rtl/sv32w_pte_eval.sv
module sv32w_pte_eval
  import sv32w_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  input  logic             lvl1,
  input  acc_e             kind,
  output logic             is_ptr,
  output logic             bad,
  output logic             need_wb,
  output logic [PTE_W-1:0] pte_wb
);
  logic v, r, w, x, a, d, allowed, super_misalign;

  always_comb begin
    v = pte[B_V];
    r = pte[B_R];
    w = pte[B_W];
    x = pte[B_X];
    a = pte[B_A];
    d = pte[B_D];
    is_ptr = v & ~r & ~w & ~x;
    unique case (kind)
      ACC_FETCH: allowed = x;
      ACC_STORE: allowed = w;
      default:   allowed = r;
    endcase
    super_misalign = lvl1 & (|pte[OFS_W+VPN_W-3:VPN_W]);
    bad = ~v | (~r & w) | (is_ptr & ~lvl1) |
          (~is_ptr & (~allowed | super_misalign));
    need_wb = ~is_ptr & ~bad & (~a | ((kind == ACC_STORE) & ~d));
    pte_wb = pte;
    pte_wb[B_A] = 1'b1;
    if (kind == ACC_STORE) pte_wb[B_D] = 1'b1;
  end
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker
  import sv32w_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_va,
  input  logic [1:0]         req_kind,
  input  logic [31:0]        satp,
  output logic               mem_req,
  output logic               mem_we,
  output logic [33:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata,
  output logic               done,
  output logic               fault,
  output logic [3:0]         cause,
  output logic [33:0]        pa,
  output logic [31:0]        fault_va
);
  localparam int unsigned SP_LO = OFS_W + VPN_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  wstate_e          state_q, state_d;
  logic [VA_W-1:0]  va_q;
  acc_e             kind_q;
  logic [PPN_W-1:0] root_q, nxt_q, nxt_d;
  logic             xlate_q;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic             fault_q, fault_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [PTE_W-1:0] wb_q, wb_d;
  logic             take_en, res_en, nxt_en, wb_en;

  logic             lvl1, is_ptr, bad, need_wb;
  logic [PTE_W-1:0] pte_wb;
  logic [CAUSE_W-1:0] kind_cause;

  logic unused_satp;
  assign unused_satp = ^satp[30:PPN_W];

  assign lvl1 = (state_q == ST_L1_RD) || (state_q == ST_L1_WB);

  sv32w_pte_addr u_addr (
    .lvl1     (lvl1),
    .root_ppn (root_q),
    .next_ppn (nxt_q),
    .va       (va_q),
    .addr     (mem_addr)
  );

  sv32w_pte_eval u_eval (
    .pte     (mem_rdata),
    .lvl1    (lvl1),
    .kind    (kind_q),
    .is_ptr  (is_ptr),
    .bad     (bad),
    .need_wb (need_wb),
    .pte_wb  (pte_wb)
  );

  always_comb begin
    unique case (kind_q)
      ACC_FETCH: kind_cause = CAUSE_FETCH_PF;
      ACC_STORE: kind_cause = CAUSE_STORE_PF;
      default:   kind_cause = CAUSE_LOAD_PF;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    take_en = 1'b0;
    res_en  = 1'b0;
    nxt_en  = 1'b0;
    wb_en   = 1'b0;
    pa_d    = pa_q;
    fault_d = 1'b0;
    cause_d = cause_q;
    nxt_d   = mem_rdata[PTE_W-1:VPN_W];
    wb_d    = pte_wb;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        take_en = 1'b1;
        res_en  = 1'b1;
        pa_d    = {2'b00, req_va};
        state_d = satp[31] ? ST_L1_RD : ST_RESP;
      end
      ST_L1_RD, ST_L0_RD: if (mem_ack) begin
        res_en = 1'b1;
        if (lvl1) pa_d = {mem_rdata[PTE_W-1:SP_LO-2], va_q[SP_LO-1:0]};
        else      pa_d = {mem_rdata[PTE_W-1:VPN_W], va_q[OFS_W-1:0]};
        if (bad) begin
          fault_d = 1'b1;
          cause_d = kind_cause;
          state_d = ST_RESP;
        end else if (is_ptr) begin
          nxt_en  = 1'b1;
          res_en  = 1'b0;
          state_d = ST_L0_RD;
        end else if (need_wb) begin
          wb_en   = 1'b1;
          state_d = lvl1 ? ST_L1_WB : ST_L0_WB;
        end else begin
          state_d = ST_RESP;
        end
      end
      ST_L1_WB, ST_L0_WB: if (mem_ack) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      kind_q  <= ACC_LOAD;
      root_q  <= '0;
      xlate_q <= 1'b0;
      nxt_q   <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      cause_q <= '0;
      wb_q    <= '0;
    end else begin
      state_q <= state_d;
      if (take_en) begin
        va_q    <= req_va;
        kind_q  <= acc_e'(req_kind);
        root_q  <= satp[PPN_W-1:0];
        xlate_q <= satp[31];
      end
      if (nxt_en) nxt_q <= nxt_d;
      if (res_en) begin
        pa_q    <= pa_d;
        fault_q <= fault_d;
        cause_q <= cause_d;
      end
      if (wb_en) wb_q <= wb_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_L1_RD) || (state_q == ST_L0_RD) ||
                     (state_q == ST_L1_WB) || (state_q == ST_L0_WB);
  assign mem_we    = (state_q == ST_L1_WB) || (state_q == ST_L0_WB);
  assign mem_wdata = wb_q;
  assign done      = (state_q == ST_RESP);
  assign fault     = fault_q;
  assign cause     = cause_q;
  assign pa        = pa_q;
  assign fault_va  = va_q;

  // input assumption: only the three defined access kinds arrive
  p_kind_legal_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid && req_ready |-> req_kind != 2'd3);

  p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_wb_sets_a_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req && mem_we |-> mem_wdata[B_A]);

  p_store_dirty_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req && mem_we && kind_q == ACC_STORE |-> mem_wdata[B_D]);

  p_bare_pass_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    done && !xlate_q |-> !fault && pa == {2'b00, va_q});

  p_page_offset_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    done && !fault |-> pa[OFS_W-1:0] == va_q[OFS_W-1:0]);

  p_fetch_cause_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    done && fault |-> (cause == CAUSE_FETCH_PF) == (kind_q == ACC_FETCH));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done && req_ready);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_ready |-> !mem_req);
endmodule

// File: tb/sv32_walker_bench.sv
`timescale 1ns/1ps
module sv32_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic [31:0] satp = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        done, fault;
  logic [3:0]  cause;
  logic [33:0] pa;
  logic [31:0] fault_va;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sv32_walker u_sv32_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_kind(req_kind), .satp(satp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .cause(cause), .pa(pa), .fault_va(fault_va)
  );

  // memory model with rotating latency
  logic [31:0] mem [logic [33:0]];
  int rd_cnt = 0, wr_cnt = 0, wait_cnt = 0, lat = 0;
  logic [33:0] last_addr = '0;
  logic [31:0] last_wdata = '0;
  logic ack_q = 1'b0;
  logic [31:0] rdata_q = '0;
  assign mem_ack = ack_q;
  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    ack_q <= 1'b0;
    if (mem_req && !ack_q) begin
      if (wait_cnt >= lat) begin
        ack_q <= 1'b1;
        last_addr <= mem_addr;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt <= wr_cnt + 1;
          last_wdata <= mem_wdata;
        end else begin
          rdata_q <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          rd_cnt <= rd_cnt + 1;
        end
        wait_cnt <= 0;
        lat <= (lat + 1) % 3;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  // R11 monitor: a pending request must stay put
  int stab_err = 0;
  logic pend = 1'b0;
  logic [33:0] paddr = '0;
  logic pwe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && pend && (!mem_req || mem_addr != paddr || mem_we != pwe))
      stab_err = stab_err + 1;
    pend  = rst_n && mem_req && !mem_ack;
    paddr = mem_addr;
    pwe   = mem_we;
  end

  task automatic load_image();
    mem.delete();
    mem[34'h1000] = 32'h0000_0000; // vpn1 0: invalid
    mem[34'h1004] = 32'h0000_0801; // vpn1 1: pointer to 0x2000
    mem[34'h1008] = 32'h0050_00CF; // vpn1 2: superpage RWX A D
    mem[34'h100C] = 32'h0060_0003; // vpn1 3: superpage R, A clear
    mem[34'h1010] = 32'h0070_044B; // vpn1 4: misaligned superpage
    mem[34'h1014] = 32'h0000_0005; // vpn1 5: W without R
    mem[34'h2000] = 32'h048D_1409; // vpn0 0: X only
    mem[34'h2004] = 32'h0004_0007; // vpn0 1: RW, A D clear
    mem[34'h2008] = 32'h0000_0C01; // vpn0 2: pointer at level 0
    mem[34'h200C] = 32'hFFFF_FCCF; // vpn0 3: full perms, top PPN
    mem[34'h3000] = 32'h0AB0_0043; // second root: superpage R A
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] satp;
    logic [31:0] va;
    logic [1:0]  kind;
    logic        flt;
    logic [3:0]  cause;
    logic [33:0] pa;
    logic [1:0]  nrd;
    logic        nwr;
    logic [31:0] wdata;
    logic [33:0] last;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0000, 32'hDEAD_BEEF, 2'd1, 1'b0, 4'd0,  34'h0_DEAD_BEEF, 2'd0, 1'b0, 32'h0,         34'h0},
    '{32'h8000_0001, 32'h0040_0123, 2'd0, 1'b0, 4'd0,  34'h0_1234_5123, 2'd2, 1'b1, 32'h048D_1449, 34'h2000},
    '{32'h8000_0001, 32'h0040_0123, 2'd1, 1'b1, 4'd13, 34'h0,           2'd2, 1'b0, 32'h0,         34'h2000},
    '{32'h8000_0001, 32'h0040_1ABC, 2'd2, 1'b0, 4'd0,  34'h0_0010_0ABC, 2'd2, 1'b1, 32'h0004_00C7, 34'h2004},
    '{32'h8000_0001, 32'h0040_1004, 2'd1, 1'b0, 4'd0,  34'h0_0010_0004, 2'd2, 1'b1, 32'h0004_0047, 34'h2004},
    '{32'h8000_0001, 32'h0040_1004, 2'd0, 1'b1, 4'd12, 34'h0,           2'd2, 1'b0, 32'h0,         34'h2004},
    '{32'h8000_0001, 32'h0040_2000, 2'd1, 1'b1, 4'd13, 34'h0,           2'd2, 1'b0, 32'h0,         34'h2008},
    '{32'h8000_0001, 32'h0040_3FFC, 2'd0, 1'b0, 4'd0,  34'h3_FFFF_FFFC, 2'd2, 1'b0, 32'h0,         34'h200C},
    '{32'h8000_0001, 32'h0000_0040, 2'd0, 1'b1, 4'd12, 34'h0,           2'd1, 1'b0, 32'h0,         34'h1000},
    '{32'h8000_0001, 32'h0093_2345, 2'd2, 1'b0, 4'd0,  34'h0_0153_2345, 2'd1, 1'b0, 32'h0,         34'h1008},
    '{32'h8000_0001, 32'h00C0_0010, 2'd1, 1'b0, 4'd0,  34'h0_0180_0010, 2'd1, 1'b1, 32'h0060_0043, 34'h100C},
    '{32'h8000_0001, 32'h00C0_0010, 2'd2, 1'b1, 4'd15, 34'h0,           2'd1, 1'b0, 32'h0,         34'h100C},
    '{32'h8000_0001, 32'h0100_0000, 2'd1, 1'b1, 4'd13, 34'h0,           2'd1, 1'b0, 32'h0,         34'h1010},
    '{32'h8000_0001, 32'h0140_0000, 2'd2, 1'b1, 4'd15, 34'h0,           2'd1, 1'b0, 32'h0,         34'h1014},
    '{32'h8000_0001, 32'h00BF_FFFE, 2'd0, 1'b0, 4'd0,  34'h0_017F_FFFE, 2'd1, 1'b0, 32'h0,         34'h1008},
    '{32'h8000_0003, 32'h0000_0444, 2'd1, 1'b0, 4'd0,  34'h0_2AC0_0444, 2'd1, 1'b0, 32'h0,         34'h3000}
  };

  task automatic run_vec(input vec_t v);
    int rd0, wr0, n;
    load_image();
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1;
    req_va = v.va;
    req_kind = v.kind;
    satp = v.satp;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R12 ready low while busy", req_ready, 0);
    n = 0;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R7 walk completes", done, 1);
    chk(fault == v.flt, "R3 R7 fault flag", fault, v.flt);
    if (v.flt) begin
      chk(cause == v.cause, "R4 cause", cause, v.cause);
      chk(fault_va == v.va, "R10 fault_va", fault_va, v.va);
    end else if (v.satp[31]) begin
      chk(pa == v.pa, "R5 R6 physical address", pa, v.pa);
    end else begin
      chk(pa == v.pa, "R1 bare address", pa, v.pa);
    end
    chk((rd_cnt - rd0) == int'(v.nrd), "R2 R7 read count", rd_cnt - rd0, v.nrd);
    if (v.nwr) begin
      chk((wr_cnt - wr0) == 1, "R8 one write-back", wr_cnt - wr0, 1);
      chk(last_wdata == v.wdata, "R8 written entry", last_wdata, v.wdata);
    end else begin
      chk(wr_cnt == wr0, "R9 no write", wr_cnt - wr0, 0);
    end
    if (v.nrd != 0)
      chk(last_addr == v.last, "R2 R8 entry address", last_addr, v.last);
    @(negedge clk);
    chk(!done && req_ready, "R12 done pulse", {done, req_ready}, 2'b01);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !done && !mem_req, "R12 reset state",
        {req_ready, done, mem_req}, 3'b100);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // directed: back-to-back store then load on the same entry keeps memory
    load_image();
    begin
      vec_t v;
      v = VEC[3];
      @(negedge clk);
      req_valid = 1'b1; req_va = v.va; req_kind = v.kind; satp = v.satp;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      chk(mem[34'h2004] == 32'h0004_00C7, "R9 flags kept after store",
          mem[34'h2004], 32'h0004_00C7);
      @(negedge clk);
    end

    // directed: reset during a walk
    load_image();
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'h0040_0000; req_kind = 2'd0; satp = 32'h8000_0001;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!mem_req && !done, "R12 reset mid-walk", {mem_req, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R12 idle after reset", req_ready, 1);

    chk(stab_err == 0, "R11 request held until ack", stab_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule